// File: doc/BRIEF.md
# Control Endpoint Status-Stage Sequencer

This block decides how endpoint zero of a device controller answers the status stage of a control transfer. The packet engine reports events as single-cycle strobes: a setup packet arrived, the data stage finished (with its direction), an IN token arrived during the status stage, the host sent a zero-length packet, or the host acknowledged a packet the device sent. For each status-stage event the block issues a one-cycle command: send a zero-length packet, send an ACK, send a STALL, or send a NAK.

Firmware steers the stage through three flags. An auto-acknowledge flag, armed ahead of time, lets the status stage finish in hardware with no CPU round trip; it is one-shot and clears itself when the stage completes. If the flag is not armed when the status stage begins, the block raises a sticky status interrupt and NAKs status tokens until firmware arms it. A stall flag overrides any acknowledgement. A status-done flag records that a device-sent zero-length status packet was acknowledged by the host.

Top module: `ctl_status_seq`

## Requirements
- R1: After reset all four flags are 0 and no command output is high.
- R2: A setup strobe clears the auto-acknowledge and stall flags at the next edge, even when firmware writes either flag in the same cycle, and starts a new data stage.
- R3: In a host-to-device transfer (direction input 0 at data-stage end), an IN token in the status stage with the flag armed and no stall gives send_zlp_o high for exactly the next cycle.
- R4: In a device-to-host transfer (direction input 1), a host zero-length packet in the status stage with the flag armed and no stall gives send_ack_o for the next cycle, completes the transfer and clears the auto-acknowledge flag at the same edge unless firmware arms it in that cycle.
- R5: When the data stage ends while the flag is unarmed and no stall is set, irq_o rises at the next edge; it stays high until firmware writes 1 to the irq clear input, and a new request in the same cycle wins over the clear.
- R6: A status-stage event while the flag is unarmed and no stall is set is answered with send_nak_o and leaves the stage pending; once firmware arms the flag, the next event is answered normally.
- R7: While the stall flag is set, every status-stage event is answered with send_stall_o, whatever the auto-acknowledge flag, and the auto-acknowledge flag is left unchanged.
- R8: After the device has sent its zero-length status packet, a host ACK sets done_o and clears the auto-acknowledge flag at the next edge; a repeated IN token before that ACK is answered again with send_zlp_o.
- R9: done_o stays high until firmware writes 1 to the done clear input.
- R10: In-token, host zero-length-packet and host-ACK strobes outside the status stage, and host zero-length packets in the wait for the host ACK, produce no command and change no flag.
- R11: At most one command output is high in any cycle, and each lasts one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_rx_i | input | 1 | Setup packet received strobe |
| data_done_i | input | 1 | Last data-stage packet done strobe |
| dir_in_i | input | 1 | Transfer direction at data_done_i: 1 device-to-host, 0 host-to-device |
| in_tok_i | input | 1 | IN token seen during status stage |
| host_zlp_i | input | 1 | Zero-length packet received from host |
| host_ack_i | input | 1 | Host ACKed the packet the device sent |
| fw_arm_i | input | 1 | Firmware sets the auto-acknowledge flag |
| fw_stall_i | input | 1 | Firmware sets the stall flag |
| fw_irq_clr_i | input | 1 | Firmware write-1-to-clear of the interrupt |
| fw_done_clr_i | input | 1 | Firmware write-1-to-clear of the done flag |
| send_zlp_o | output | 1 | Command: send zero-length data packet |
| send_ack_o | output | 1 | Command: send ACK handshake |
| send_stall_o | output | 1 | Command: send STALL handshake |
| send_nak_o | output | 1 | Command: send NAK handshake |
| auto_ack_o | output | 1 | Auto-acknowledge flag |
| stall_o | output | 1 | Stall flag |
| irq_o | output | 1 | Status interrupt request |
| done_o | output | 1 | Status-done flag |

## Verification
A wrong phase or a stale latched direction shows up at the first status-stage event after it: the command on the next cycle is the wrong one, or missing, and the auto-acknowledge flag fails to clear on that same edge. A flag with a bad priority against setup or firmware writes is visible on its output one cycle after the colliding strobes. The bench therefore compares every output against a model on every cycle, so a fault surfaces within one cycle of the event that exposes it.

// File: rtl/ctl_status_pkg.sv
package ctl_status_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_STAT,
        PH_ZLPW
    } phase_e;

    typedef enum logic [2:0] {
        RSP_NONE,
        RSP_ZLP,
        RSP_ACK,
        RSP_STALL,
        RSP_NAK
    } rsp_e;

    typedef struct packed {
        logic setup;
        logic data_done;
        logic dir_in;
        logic in_tok;
        logic host_zlp;
        logic host_ack;
    } pkt_ev_t;

    typedef struct packed {
        logic arm;
        logic stall;
        logic irq_clr;
        logic done_clr;
    } fw_wr_t;

    typedef struct packed {
        logic auto_ack;
        logic stall;
        logic irq;
        logic done;
    } flags_t;

    typedef struct packed {
        logic complete;
        logic done_set;
        logic irq_set;
    } fsm_evt_t;

    // Answer to a status-stage event given the current firmware flags.
    function automatic rsp_e stat_answer(logic stalled, logic armed, logic dir_in);
        if (stalled)
            return RSP_STALL;
        else if (armed)
            return dir_in ? RSP_ACK : RSP_ZLP;
        else
            return RSP_NAK;
    endfunction

    // Bit order of the command vector: {zlp, ack, stall, nak}.
    function automatic logic [CMD_W-1:0] rsp_onehot(rsp_e r);
        logic [CMD_W-1:0] v;
        v = '0;
        case (r)
            RSP_ZLP:   v[3] = 1'b1;
            RSP_ACK:   v[2] = 1'b1;
            RSP_STALL: v[1] = 1'b1;
            RSP_NAK:   v[0] = 1'b1;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ctl_status_flags.sv
module ctl_status_flags
    import ctl_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     setup_i,
    input  fw_wr_t   fw_i,
    input  fsm_evt_t evt_i,
    output flags_t   flags_o
);

    flags_t flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            if (setup_i)
                flg_q.auto_ack <= 1'b0;
            else if (fw_i.arm)
                flg_q.auto_ack <= 1'b1;
            else if (evt_i.complete)
                flg_q.auto_ack <= 1'b0;

            if (setup_i)
                flg_q.stall <= 1'b0;
            else if (fw_i.stall)
                flg_q.stall <= 1'b1;

            if (evt_i.irq_set)
                flg_q.irq <= 1'b1;
            else if (fw_i.irq_clr)
                flg_q.irq <= 1'b0;

            if (evt_i.done_set)
                flg_q.done <= 1'b1;
            else if (fw_i.done_clr)
                flg_q.done <= 1'b0;
        end
    end

    assign flags_o = flg_q;

endmodule

// File: rtl/ctl_status_fsm.sv
module ctl_status_fsm
    import ctl_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pkt_ev_t  ev_i,
    input  logic     armed_i,
    input  logic     stalled_i,
    output rsp_e     rsp_o,
    output fsm_evt_t evt_o
);

    phase_e ph_q, ph_d;
    logic   dir_q, dir_d;
    rsp_e   rsp_q, rsp_d;
    logic   stat_ev;

    assign stat_ev = dir_q ? ev_i.host_zlp : ev_i.in_tok;

    always_comb begin
        ph_d  = ph_q;
        dir_d = dir_q;
        rsp_d = RSP_NONE;
        evt_o = '0;
        if (ev_i.setup) begin
            ph_d = PH_DATA;
        end else begin
            case (ph_q)
                PH_DATA: begin
                    if (ev_i.data_done) begin
                        ph_d  = PH_STAT;
                        dir_d = ev_i.dir_in;
                        evt_o.irq_set = !armed_i && !stalled_i;
                    end
                end
                PH_STAT: begin
                    if (stat_ev) begin
                        rsp_d = stat_answer(stalled_i, armed_i, dir_q);
                        if (rsp_d == RSP_ACK) begin
                            evt_o.complete = 1'b1;
                            ph_d = PH_IDLE;
                        end else if (rsp_d == RSP_ZLP) begin
                            ph_d = PH_ZLPW;
                        end
                    end
                end
                PH_ZLPW: begin
                    if (ev_i.host_ack) begin
                        evt_o.complete = 1'b1;
                        evt_o.done_set = 1'b1;
                        ph_d = PH_IDLE;
                    end else if (ev_i.in_tok) begin
                        rsp_d = stat_answer(stalled_i, armed_i, 1'b0);
                    end
                end
                default: ph_d = ph_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            dir_q <= 1'b0;
            rsp_q <= RSP_NONE;
        end else begin
            ph_q  <= ph_d;
            dir_q <= dir_d;
            rsp_q <= rsp_d;
        end
    end

    assign rsp_o = rsp_q;

endmodule

// File: rtl/ctl_status_cmd.sv
module ctl_status_cmd
    import ctl_status_pkg::*;
(
    input  rsp_e             rsp_i,
    output logic [CMD_W-1:0] cmd_o
);

    assign cmd_o = rsp_onehot(rsp_i);

endmodule

// File: rtl/ctl_status_seq.sv
module ctl_status_seq
    import ctl_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic setup_rx_i,
    input  logic data_done_i,
    input  logic dir_in_i,
    input  logic in_tok_i,
    input  logic host_zlp_i,
    input  logic host_ack_i,
    input  logic fw_arm_i,
    input  logic fw_stall_i,
    input  logic fw_irq_clr_i,
    input  logic fw_done_clr_i,
    output logic send_zlp_o,
    output logic send_ack_o,
    output logic send_stall_o,
    output logic send_nak_o,
    output logic auto_ack_o,
    output logic stall_o,
    output logic irq_o,
    output logic done_o
);

    pkt_ev_t          ev;
    fw_wr_t           fw;
    fsm_evt_t         evt;
    flags_t           flg;
    rsp_e             rsp;
    logic [CMD_W-1:0] cmd;

    assign ev = '{setup: setup_rx_i, data_done: data_done_i, dir_in: dir_in_i,
                  in_tok: in_tok_i, host_zlp: host_zlp_i, host_ack: host_ack_i};
    assign fw = '{arm: fw_arm_i, stall: fw_stall_i,
                  irq_clr: fw_irq_clr_i, done_clr: fw_done_clr_i};

    ctl_status_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .armed_i   (flg.auto_ack),
        .stalled_i (flg.stall),
        .rsp_o     (rsp),
        .evt_o     (evt)
    );

    ctl_status_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .setup_i (setup_rx_i),
        .fw_i    (fw),
        .evt_i   (evt),
        .flags_o (flg)
    );

    ctl_status_cmd u_cmd (
        .rsp_i (rsp),
        .cmd_o (cmd)
    );

    assign {send_zlp_o, send_ack_o, send_stall_o, send_nak_o} = cmd;
    assign auto_ack_o = flg.auto_ack;
    assign stall_o    = flg.stall;
    assign irq_o      = flg.irq;
    assign done_o     = flg.done;

endmodule

// File: rtl/ctl_status_chk.sv
module ctl_status_chk (
    input logic clk,
    input logic rst,
    input logic setup_rx_i,
    input logic data_done_i,
    input logic host_ack_i,
    input logic fw_arm_i,
    input logic send_zlp_o,
    input logic send_ack_o,
    input logic send_stall_o,
    input logic send_nak_o,
    input logic auto_ack_o,
    input logic stall_o,
    input logic irq_o,
    input logic done_o
);

    // R11
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({send_zlp_o, send_ack_o, send_stall_o, send_nak_o}));

    // R2
    setup_clears_chk: assert property (@(posedge clk) disable iff (rst)
        setup_rx_i |=> (!auto_ack_o && !stall_o));

    // R3
    zlp_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        send_zlp_o |-> ($past(auto_ack_o) && !$past(stall_o)));

    // R4
    ack_clears_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (send_ack_o && !$past(fw_arm_i)) |-> !auto_ack_o);

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(data_done_i));

    // R6
    nak_when_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        send_nak_o |-> !$past(auto_ack_o));

    // R7
    stall_answer_chk: assert property (@(posedge clk) disable iff (rst)
        send_stall_o |-> $past(stall_o));

    // R8
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(host_ack_i));

endmodule

bind ctl_status_seq ctl_status_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .setup_rx_i   (setup_rx_i),
    .data_done_i  (data_done_i),
    .host_ack_i   (host_ack_i),
    .fw_arm_i     (fw_arm_i),
    .send_zlp_o   (send_zlp_o),
    .send_ack_o   (send_ack_o),
    .send_stall_o (send_stall_o),
    .send_nak_o   (send_nak_o),
    .auto_ack_o   (auto_ack_o),
    .stall_o      (stall_o),
    .irq_o        (irq_o),
    .done_o       (done_o)
);

// File: tb/tb_ctl_status_seq.sv
`timescale 1ns/1ps
module tb_ctl_status_seq;

    typedef struct packed {
        logic setup;
        logic ddone;
        logic dir;
        logic intok;
        logic hzlp;
        logic hack;
        logic arm;
        logic stall;
        logic iclr;
        logic dclr;
    } stim_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    stim_t s_in = '0;

    logic send_zlp, send_ack, send_stall, send_nak;
    logic auto_ack, stall, irq, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // expected-state model
    int         m_st = 0;  // 0 idle, 1 data, 2 status, 3 wait host ack
    logic       m_dir = 1'b0;
    logic       m_auto = 1'b0, m_stall = 1'b0, m_irq = 1'b0, m_done = 1'b0;
    logic [3:0] m_cmd = 4'b0;

    always #2 clk = ~clk;

    ctl_status_seq dut (
        .clk          (clk),
        .rst          (rst),
        .setup_rx_i   (s_in.setup),
        .data_done_i  (s_in.ddone),
        .dir_in_i     (s_in.dir),
        .in_tok_i     (s_in.intok),
        .host_zlp_i   (s_in.hzlp),
        .host_ack_i   (s_in.hack),
        .fw_arm_i     (s_in.arm),
        .fw_stall_i   (s_in.stall),
        .fw_irq_clr_i (s_in.iclr),
        .fw_done_clr_i(s_in.dclr),
        .send_zlp_o   (send_zlp),
        .send_ack_o   (send_ack),
        .send_stall_o (send_stall),
        .send_nak_o   (send_nak),
        .auto_ack_o   (auto_ack),
        .stall_o      (stall),
        .irq_o        (irq),
        .done_o       (done)
    );

    // {zlp, ack, stall, nak}
    function automatic logic [3:0] answer(logic st, logic armed, logic dir);
        if (st) return 4'b0010;
        if (armed) return dir ? 4'b0100 : 4'b1000;
        return 4'b0001;
    endfunction

    task automatic model_step(stim_t s);
        logic [3:0] cmd = 4'b0;
        logic cmplt = 1'b0, dset = 1'b0, iset = 1'b0;
        int   st_n = m_st;
        logic dir_n = m_dir;
        if (s.setup) st_n = 1;
        else if (m_st == 1) begin
            if (s.ddone) begin
                st_n = 2; dir_n = s.dir; iset = !m_auto && !m_stall;
            end
        end else if (m_st == 2) begin
            if (m_dir ? s.hzlp : s.intok) begin
                cmd = answer(m_stall, m_auto, m_dir);
                if (cmd == 4'b0100) begin cmplt = 1'b1; st_n = 0; end
                else if (cmd == 4'b1000) st_n = 3;
            end
        end else if (m_st == 3) begin
            if (s.hack) begin cmplt = 1'b1; dset = 1'b1; st_n = 0; end
            else if (s.intok) cmd = answer(m_stall, m_auto, 1'b0);
        end
        m_auto  = s.setup ? 1'b0 : s.arm ? 1'b1 : cmplt ? 1'b0 : m_auto;
        m_stall = s.setup ? 1'b0 : s.stall ? 1'b1 : m_stall;
        m_irq   = iset ? 1'b1 : s.iclr ? 1'b0 : m_irq;
        m_done  = dset ? 1'b1 : s.dclr ? 1'b0 : m_done;
        m_cmd = cmd; m_st = st_n; m_dir = dir_n;
    endtask

    task automatic compare(string tag);
        logic [7:0] got, exp;
        got = {send_zlp, send_ack, send_stall, send_nak, auto_ack, stall, irq, done};
        exp = {m_cmd, m_auto, m_stall, m_irq, m_done};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (cmd zlp,ack,stall,nak | auto,stall,irq,done) at %0t",
                     tag, got, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, model, step one cycle, compare.
    task automatic cyc(string tag, stim_t s);
        s_in = s;
        model_step(s);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R10: stray strobes while idle
        s = '0; s.intok = 1; s.hzlp = 1; s.hack = 1; cyc("R10", s);
        s = '0; s.ddone = 1; cyc("R10", s);

        // host-to-device, armed: R3, R8, R9
        s = '0; s.setup = 1; cyc("R2", s);
        s = '0; s.intok = 1; cyc("R10", s);
        s = '0; s.arm = 1; cyc("R3", s);
        s = '0; s.ddone = 1; s.dir = 0; cyc("R5", s);
        s = '0; s.hzlp = 1; cyc("R10", s);
        s = '0; s.intok = 1; cyc("R3", s);
        s = '0; s.hzlp = 1; cyc("R10", s);
        s = '0; s.intok = 1; cyc("R8", s);
        s = '0; s.hack = 1; cyc("R8", s);
        s = '0; cyc("R9", s);
        s = '0; s.dclr = 1; cyc("R9", s);

        // device-to-host, unarmed: R5, R6, R4
        s = '0; s.setup = 1; cyc("R2", s);
        s = '0; s.ddone = 1; s.dir = 1; cyc("R5", s);
        s = '0; s.hzlp = 1; cyc("R6", s);
        s = '0; s.intok = 1; cyc("R10", s);
        s = '0; s.iclr = 1; cyc("R5", s);
        s = '0; s.arm = 1; cyc("R6", s);
        s = '0; s.hzlp = 1; cyc("R4", s);
        s = '0; s.hzlp = 1; cyc("R10", s);

        // irq set wins over clear
        s = '0; s.setup = 1; cyc("R2", s);
        s = '0; s.ddone = 1; s.iclr = 1; cyc("R5", s);

        // stall override: R7, then setup colliding with firmware writes: R2
        s = '0; s.setup = 1; cyc("R2", s);
        s = '0; s.arm = 1; s.stall = 1; cyc("R7", s);
        s = '0; s.ddone = 1; s.dir = 1; cyc("R7", s);
        s = '0; s.hzlp = 1; cyc("R7", s);
        s = '0; s.hzlp = 1; cyc("R7", s);
        s = '0; s.setup = 1; s.arm = 1; s.stall = 1; cyc("R2", s);

        // arm in the same cycle as completion keeps the flag: R4
        s = '0; s.arm = 1; cyc("R4", s);
        s = '0; s.ddone = 1; s.dir = 1; cyc("R4", s);
        s = '0; s.hzlp = 1; s.arm = 1; cyc("R4", s);

        // constrained random traffic
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            s = '0;
            s.setup = ($urandom_range(0, 29) == 0);
            s.ddone = ($urandom_range(0, 5) == 0);
            s.dir   = $urandom_range(0, 1);
            s.intok = ($urandom_range(0, 3) == 0);
            s.hzlp  = ($urandom_range(0, 3) == 0);
            s.hack  = ($urandom_range(0, 4) == 0);
            s.arm   = ($urandom_range(0, 6) == 0);
            s.stall = ($urandom_range(0, 24) == 0);
            s.iclr  = ($urandom_range(0, 5) == 0);
            s.dclr  = ($urandom_range(0, 5) == 0);
            cyc("R11", s);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule